// File: doc/BRIEF.md
# Transmit Ring Buffer Allocator

This block hands out space for outgoing frames in the transmit part of a packet buffer RAM. The same RAM also holds the receive area. Software or a sequencer gives the block the region layout: which area comes first in the RAM, and how many bytes go to receive. The transmit area is whatever the receive area leaves over. It starts directly after the receive area and wraps modulo the RAM size.

A request gives a frame length. The block reserves a record made of the length rounded up to whole 16-bit words, plus one extra word, plus a fixed header. The record is placed at the current tail pointer. The block returns the record's start and end addresses and advances the tail. If the record would reach the wrap page, the record is not split. It restarts at the bottom of the region instead.

A release moves the head pointer when frames have been sent. The free byte count is always visible, and a request that does not fit is refused.

Top module: `txr_alloc`

## Requirements
- R1: While reset is held, and right after it is released, the head and tail pointers equal the default transmit base, which is 0x6000 for the default 0x6000-byte receive area placed first in a 0x8000-byte RAM. The free count equals the region size (0x2000), and neither response strobe is set.
- R2: On an init strobe, both pointers move to the region's bottom address. The region geometry is as follows:
  - When `cfg_tx_first` is 0, the receive area starts at 0. When it is 1, the receive area starts at RAM size minus receive size.
  - The transmit base is (receive base + receive size) modulo the RAM size.
  - The region size is the RAM size minus the receive size.
  - The bottom address is the transmit base rounded down to a 256-byte page.
- R3: An accepted request reserves (((len + 3) >> 1) << 1) + HDR_BYTES bytes (HDR_BYTES = 8 by default) starting at the tail. One cycle after the request, `alloc_done` pulses, `alloc_start` and `alloc_end` hold the record bounds, and the tail equals `alloc_end`.
- R4: The wrap address is ((base + size − 2) >> 8) << 8. If tail + record size is greater than or equal to the wrap address, the record starts at the bottom address and its end is recomputed from there.
- R5: The free count is computed from the head and tail pointers:
  - tail > head gives size − (tail − head).
  - tail < head gives head − tail.
  - Equal pointers give the full region size.
- R6: A request whose length is greater than the free count pulses `alloc_nospace` one cycle later and leaves the tail unchanged. A length equal to the free count is accepted.
- R7: A release sets the head to `rel_ptr` one cycle later. An allocation in the same cycle also takes effect, and its space check uses the pointers from before that cycle.
- R8: An init strobe overrides a request and a release in the same cycle. No response strobe follows, and both pointers go to the bottom address.
- R9: `alloc_done` and `alloc_nospace` are never set together. Each is a one-cycle pulse that only follows a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx_first | input | 1 | 1: transmit area placed before receive area |
| cfg_rx_bytes | input | 16 | Receive area size in bytes |
| init_req | input | 1 | Reset both pointers to the region bottom |
| alloc_req | input | 1 | Allocation strobe |
| alloc_len | input | 16 | Frame length in bytes |
| rel_req | input | 1 | Release strobe |
| rel_ptr | input | 16 | New head pointer |
| alloc_done | output | 1 | Record granted (pulse) |
| alloc_nospace | output | 1 | Request refused for lack of space (pulse) |
| alloc_start | output | 16 | Start address of the last granted record |
| alloc_end | output | 16 | End address of the last granted record |
| head_ptr | output | 16 | Oldest byte still in use |
| tail_ptr | output | 16 | Next free address |
| free_bytes | output | 16 | Free byte count in the region |

## Verification
The bound checker tests the strobe rules on every cycle. It checks that the two response strobes are exclusive and are caused by a request. It checks that a refusal keeps the tail, that a grant leaves the tail at the reported end, that a release lands on the given pointer, that init suppresses responses, and that a start address differing from the old tail only moves backwards, which is a wrap. The exact record sizes, the wrap threshold including its equality case, the three free-count cases, the acceptance at exactly the free count, and the region geometry under both layouts depend on arithmetic. Only the bench's scenarios with precomputed addresses can show these.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [1:0] {
    TAIL_HOLD,
    TAIL_INIT,
    TAIL_ADVANCE
  } tail_act_e;

  typedef enum logic [1:0] {
    HEAD_HOLD,
    HEAD_INIT,
    HEAD_RELEASE
  } head_act_e;
endpackage

// File: rtl/txr_region.sv
module txr_region #(
  parameter int RAM_BYTES = 32768,
  parameter int PW        = 16
) (
  input  logic          cfg_tx_first,
  input  logic [PW-1:0] cfg_rx_bytes,
  output logic [PW-1:0] tx_base,
  output logic [PW-1:0] tx_size,
  output logic [PW-1:0] lo_addr,
  output logic [PW-1:0] wrap_addr
);
  localparam logic [PW-1:0] RAM_W = PW'(RAM_BYTES);

  logic [PW-1:0] rx_base;
  logic [PW-1:0] top_byte;

  always_comb begin
    rx_base   = cfg_tx_first ? (RAM_W - cfg_rx_bytes) : '0;
    tx_base   = (rx_base + cfg_rx_bytes) % RAM_W;
    tx_size   = RAM_W - cfg_rx_bytes;
    lo_addr   = (tx_base >> 8) << 8;
    top_byte  = tx_base + tx_size - PW'(2);
    wrap_addr = (top_byte >> 8) << 8;
  end
endmodule

// File: rtl/txr_free.sv
module txr_free #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] head,
  input  logic [PW-1:0] tail,
  input  logic [PW-1:0] size,
  output logic [PW-1:0] free_cnt
);
  always_comb begin
    if (tail > head)
      free_cnt = size - (tail - head);
    else if (tail < head)
      free_cnt = head - tail;
    else
      free_cnt = size;
  end
endmodule

// File: rtl/txr_place.sv
module txr_place #(
  parameter int PW        = 16,
  parameter int HDR_BYTES = 8
) (
  input  logic [PW-1:0] tail,
  input  logic [PW-1:0] len,
  input  logic [PW-1:0] lo_addr,
  input  logic [PW-1:0] wrap_addr,
  output logic [PW-1:0] rec_start,
  output logic [PW-1:0] rec_end
);
  logic [PW-1:0] rec_bytes;
  logic [PW-1:0] cand_end;

  always_comb begin
    rec_bytes = (((len + PW'(3)) >> 1) << 1) + PW'(HDR_BYTES);
    cand_end  = tail + rec_bytes;
    if (cand_end >= wrap_addr) begin
      rec_start = lo_addr;
      rec_end   = lo_addr + rec_bytes;
    end else begin
      rec_start = tail;
      rec_end   = cand_end;
    end
  end
endmodule

// File: rtl/txr_alloc.sv
module txr_alloc #(
  parameter int RAM_BYTES    = 32768,
  parameter int RX_BYTES_DEF = 24576,
  parameter bit TX_FIRST_DEF = 1'b0,
  parameter int HDR_BYTES    = 8,
  parameter int PW           = $clog2(RAM_BYTES) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_tx_first,
  input  logic [PW-1:0] cfg_rx_bytes,
  input  logic          init_req,
  input  logic          alloc_req,
  input  logic [PW-1:0] alloc_len,
  input  logic          rel_req,
  input  logic [PW-1:0] rel_ptr,
  output logic          alloc_done,
  output logic          alloc_nospace,
  output logic [PW-1:0] alloc_start,
  output logic [PW-1:0] alloc_end,
  output logic [PW-1:0] head_ptr,
  output logic [PW-1:0] tail_ptr,
  output logic [PW-1:0] free_bytes
);
  import txr_pkg::*;

  localparam int RST_BASE_I = TX_FIRST_DEF ? 0 : (RX_BYTES_DEF % RAM_BYTES);
  localparam logic [PW-1:0] RST_BASE = PW'((RST_BASE_I >> 8) << 8);

  logic [PW-1:0] tx_base, tx_size, lo_addr, wrap_addr;
  logic [PW-1:0] rec_start, rec_end, free_cnt;

  logic [PW-1:0] head_q, tail_q, astart_q, aend_q;
  logic          done_q, nsp_q;
  logic [PW-1:0] head_d, tail_d, astart_d, aend_d;
  logic          done_d, nsp_d;
  logic          grant_en;
  tail_act_e     tail_act;
  head_act_e     head_act;

  txr_region #(.RAM_BYTES(RAM_BYTES), .PW(PW)) u_region (
    .cfg_tx_first (cfg_tx_first),
    .cfg_rx_bytes (cfg_rx_bytes),
    .tx_base      (tx_base),
    .tx_size      (tx_size),
    .lo_addr      (lo_addr),
    .wrap_addr    (wrap_addr)
  );

  txr_free #(.PW(PW)) u_free (
    .head     (head_q),
    .tail     (tail_q),
    .size     (tx_size),
    .free_cnt (free_cnt)
  );

  txr_place #(.PW(PW), .HDR_BYTES(HDR_BYTES)) u_place (
    .tail      (tail_q),
    .len       (alloc_len),
    .lo_addr   (lo_addr),
    .wrap_addr (wrap_addr),
    .rec_start (rec_start),
    .rec_end   (rec_end)
  );

  // action decode: init wins over everything else
  always_comb begin
    tail_act = TAIL_HOLD;
    head_act = HEAD_HOLD;
    done_d   = 1'b0;
    nsp_d    = 1'b0;
    grant_en = 1'b0;
    if (init_req) begin
      tail_act = TAIL_INIT;
      head_act = HEAD_INIT;
    end else begin
      if (rel_req) head_act = HEAD_RELEASE;
      if (alloc_req) begin
        if (alloc_len > free_cnt) begin
          nsp_d = 1'b1;
        end else begin
          done_d   = 1'b1;
          grant_en = 1'b1;
          tail_act = TAIL_ADVANCE;
        end
      end
    end
  end

  // next state
  always_comb begin
    unique case (tail_act)
      TAIL_INIT:    tail_d = lo_addr;
      TAIL_ADVANCE: tail_d = rec_end;
      default:      tail_d = tail_q;
    endcase
    unique case (head_act)
      HEAD_INIT:    head_d = lo_addr;
      HEAD_RELEASE: head_d = rel_ptr;
      default:      head_d = head_q;
    endcase
    astart_d = grant_en ? rec_start : astart_q;
    aend_d   = grant_en ? rec_end   : aend_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q   <= RST_BASE;
      tail_q   <= RST_BASE;
      astart_q <= RST_BASE;
      aend_q   <= RST_BASE;
      done_q   <= 1'b0;
      nsp_q    <= 1'b0;
    end else begin
      head_q   <= head_d;
      tail_q   <= tail_d;
      astart_q <= astart_d;
      aend_q   <= aend_d;
      done_q   <= done_d;
      nsp_q    <= nsp_d;
    end
  end

  assign alloc_done    = done_q;
  assign alloc_nospace = nsp_q;
  assign alloc_start   = astart_q;
  assign alloc_end     = aend_q;
  assign head_ptr      = head_q;
  assign tail_ptr      = tail_q;
  assign free_bytes    = free_cnt;
endmodule

// File: rtl/txr_alloc_chk.sv
module txr_alloc_chk #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init_req,
  input logic          alloc_req,
  input logic          rel_req,
  input logic [PW-1:0] rel_ptr,
  input logic          alloc_done,
  input logic          alloc_nospace,
  input logic [PW-1:0] alloc_start,
  input logic [PW-1:0] alloc_end,
  input logic [PW-1:0] head_ptr,
  input logic [PW-1:0] tail_ptr
);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_done && alloc_nospace));

  a_r9_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_done || alloc_nospace) |-> $past(alloc_req && !init_req));

  a_r6_tail_kept: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_nospace |-> tail_ptr == $past(tail_ptr));

  a_r3_tail_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |-> tail_ptr == alloc_end);

  a_r4_restart_back: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_done && alloc_start != $past(tail_ptr)) |-> alloc_start < $past(tail_ptr));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rel_req && !init_req) |-> head_ptr == $past(rel_ptr));

  a_r8_init_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(init_req) |-> (!alloc_done && !alloc_nospace && head_ptr == tail_ptr));
endmodule

bind txr_alloc txr_alloc_chk #(.PW(PW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .init_req      (init_req),
  .alloc_req     (alloc_req),
  .rel_req       (rel_req),
  .rel_ptr       (rel_ptr),
  .alloc_done    (alloc_done),
  .alloc_nospace (alloc_nospace),
  .alloc_start   (alloc_start),
  .alloc_end     (alloc_end),
  .head_ptr      (head_ptr),
  .tail_ptr      (tail_ptr)
);

// File: tb/txr_alloc_bench.sv
module txr_alloc_bench;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_tx_first = 1'b0;
  logic [PW-1:0] cfg_rx_bytes = 16'h6000;
  logic          init_req = 1'b0;
  logic          alloc_req = 1'b0;
  logic [PW-1:0] alloc_len = '0;
  logic          rel_req = 1'b0;
  logic [PW-1:0] rel_ptr = '0;
  logic          alloc_done, alloc_nospace;
  logic [PW-1:0] alloc_start, alloc_end, head_ptr, tail_ptr, free_bytes;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  txr_alloc u_txr_alloc (
    .clk(clk), .rst_n(rst_n), .cfg_tx_first(cfg_tx_first),
    .cfg_rx_bytes(cfg_rx_bytes), .init_req(init_req), .alloc_req(alloc_req),
    .alloc_len(alloc_len), .rel_req(rel_req), .rel_ptr(rel_ptr),
    .alloc_done(alloc_done), .alloc_nospace(alloc_nospace),
    .alloc_start(alloc_start), .alloc_end(alloc_end),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr), .free_bytes(free_bytes)
  );

  typedef struct packed {
    logic        ini;
    logic        alc;
    logic        rel;
    logic        txf;
    logic [15:0] rx;
    logic [15:0] len;
    logic [15:0] ptr;
    logic        e_done;
    logic        e_nsp;
    logic [15:0] e_as;
    logic [15:0] e_ae;
    logic [15:0] e_head;
    logic [15:0] e_tail;
    logic [15:0] e_free;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    // R3: len 60 -> 70-byte record at 0x6000
    '{1'b0,1'b1,1'b0,1'b0,16'h6000,16'd60,16'h0,   1'b1,1'b0,16'h6000,16'h6046,16'h6000,16'h6046,16'd8122},
    // R3: odd length rounding, R5 tail > head
    '{1'b0,1'b1,1'b0,1'b0,16'h6000,16'd61,16'h0,   1'b1,1'b0,16'h6046,16'h608E,16'h6000,16'h608E,16'd8050},
    // R7 release, R5 equal pointers
    '{1'b0,1'b0,1'b1,1'b0,16'h6000,16'd0,16'h608E, 1'b0,1'b0,16'h6046,16'h608E,16'h608E,16'h608E,16'd8192},
    // R4: stays below the wrap address
    '{1'b0,1'b1,1'b0,1'b0,16'h6000,16'd7000,16'h0, 1'b1,1'b0,16'h608E,16'h7BF0,16'h608E,16'h7BF0,16'd1182},
    // R6: one byte over free count
    '{1'b0,1'b1,1'b0,1'b0,16'h6000,16'd1183,16'h0, 1'b0,1'b1,16'h608E,16'h7BF0,16'h608E,16'h7BF0,16'd1182},
    // R6 exactly free accepted, R4 restart at bottom
    '{1'b0,1'b1,1'b0,1'b0,16'h6000,16'd1182,16'h0, 1'b1,1'b0,16'h6000,16'h64A8,16'h608E,16'h64A8,16'd7142},
    // R5: tail < head
    '{1'b0,1'b0,1'b1,1'b0,16'h6000,16'd0,16'h7000, 1'b0,1'b0,16'h6000,16'h64A8,16'h7000,16'h64A8,16'd2904},
    // R6 refused
    '{1'b0,1'b1,1'b0,1'b0,16'h6000,16'd3000,16'h0, 1'b0,1'b1,16'h6000,16'h64A8,16'h7000,16'h64A8,16'd2904},
    // R2: transmit-first layout init
    '{1'b1,1'b0,1'b0,1'b1,16'h6000,16'd0,16'h0,    1'b0,1'b0,16'h6000,16'h64A8,16'h0000,16'h0000,16'd8192},
    // R3 in transmit-first layout
    '{1'b0,1'b1,1'b0,1'b1,16'h6000,16'd100,16'h0,  1'b1,1'b0,16'h0000,16'h006E,16'h0000,16'h006E,16'd8082},
    // R7: alloc and release together
    '{1'b0,1'b1,1'b1,1'b1,16'h6000,16'd20,16'h006E,1'b1,1'b0,16'h006E,16'h008C,16'h006E,16'h008C,16'd8162},
    // R8: init overrides alloc; R2 16K transmit-first
    '{1'b1,1'b1,1'b0,1'b1,16'h4000,16'd50,16'h0,   1'b0,1'b0,16'h006E,16'h008C,16'h0000,16'h0000,16'd16384},
    // R2: receive-first with 16K receive
    '{1'b1,1'b0,1'b0,1'b0,16'h4000,16'd0,16'h0,    1'b0,1'b0,16'h006E,16'h008C,16'h4000,16'h4000,16'd16384},
    // R3: zero length gives header plus one word
    '{1'b0,1'b1,1'b0,1'b0,16'h4000,16'd0,16'h0,    1'b1,1'b0,16'h4000,16'h400A,16'h4000,16'h400A,16'd16374},
    // R4: candidate end equals wrap address exactly
    '{1'b0,1'b1,1'b0,1'b0,16'h4000,16'd16108,16'h0,1'b1,1'b0,16'h4000,16'h7EF6,16'h4000,16'h7EF6,16'd266}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle_default(input string req);
    chk(req, "head", int'(head_ptr), 'h6000);
    chk(req, "tail", int'(tail_ptr), 'h6000);
    chk(req, "free", int'(free_bytes), 8192);
    chk(req, "done", int'(alloc_done), 0);
    chk(req, "nospace", int'(alloc_nospace), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_idle_default("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_idle_default("R1 after release");

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      init_req     = VEC[i].ini;
      alloc_req    = VEC[i].alc;
      rel_req      = VEC[i].rel;
      cfg_tx_first = VEC[i].txf;
      cfg_rx_bytes = VEC[i].rx;
      alloc_len    = VEC[i].len;
      rel_ptr      = VEC[i].ptr;
      @(posedge clk);
      #1;
      init_req  = 1'b0;
      alloc_req = 1'b0;
      rel_req   = 1'b0;
      chk($sformatf("row%0d done", i), "alloc_done", int'(alloc_done), int'(VEC[i].e_done));
      chk($sformatf("row%0d nospace", i), "alloc_nospace", int'(alloc_nospace), int'(VEC[i].e_nsp));
      chk($sformatf("row%0d", i), "alloc_start", int'(alloc_start), int'(VEC[i].e_as));
      chk($sformatf("row%0d", i), "alloc_end", int'(alloc_end), int'(VEC[i].e_ae));
      chk($sformatf("row%0d", i), "head", int'(head_ptr), int'(VEC[i].e_head));
      chk($sformatf("row%0d", i), "tail", int'(tail_ptr), int'(VEC[i].e_tail));
      chk($sformatf("row%0d", i), "free", int'(free_bytes), int'(VEC[i].e_free));
      @(posedge clk);
      #1;
      chk("R9 pulse ends", "done|nospace", int'(alloc_done | alloc_nospace), 0);
    end

    // R1: asynchronous reset in mid-cycle restores the default pointers
    @(negedge clk);
    cfg_tx_first = 1'b0;
    cfg_rx_bytes = 16'h6000;
    #2;
    rst_n = 1'b0;
    #1;
    check_idle_default("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_idle_default("R1 after second release");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule